// File: doc/BRIEF.md
# Priority Interrupt Controller with Vectoring

This block collects interrupt requests from eight device lines and presents one interrupt signal to a processor. A rising edge on any line records a pending request. Each line has its own mask bit. A masked request stays recorded but takes no part in arbitration until its mask bit is cleared. Priority is fixed, with line 0 the highest and line 7 the lowest. The interrupt output is raised when an unmasked pending request outranks every request that is already in service.

The processor answers with two acknowledge pulses. On the rising edge of the first pulse, the winning request moves from the pending set to the in-service set. On the second pulse, the block drives the vector `32 + N` onto an 8-bit bus with a drive-enable, where N is the winning line. After its handler finishes, software writes an end-of-interrupt command. That command retires the highest-priority in-service entry so that lower-priority requests can be delivered.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all eight mask bits are set, no request is pending or in service, `int_o` and `vec_oe_o` are low and `vec_o` is zero.
- R2: A rising edge on `irq_i[n]` records a pending request for line n whatever its mask bit. The request stays recorded after the line falls, until it is acknowledged.
- R3: A write with `wr_sel_i`=0 loads `wr_data_i[7:0]` into the mask, where bit n=1 masks line n. A masked pending request is skipped in arbitration. It raises `int_o` in the cycle after its mask bit is cleared.
- R4: While no acknowledge is in progress, `int_o` is high exactly when some unmasked pending line has a lower index than every in-service line. Line 0 has the highest priority.
- R5: On the rising edge of the first acknowledge pulse, the lowest-index eligible line leaves the pending set and enters the in-service set. `int_o` stays low until the handshake ends.
- R6: On the rising edge of the second pulse, `vec_oe_o` rises in the next cycle and stays high until the cycle after `inta_i` falls. While it is high, `vec_o` = 32 + N.
- R7: If no line is eligible at the first pulse, the vector is 39 and neither the pending set nor the in-service set changes.
- R8: A write with `wr_sel_i`=1 and `wr_data_i[5]`=1 clears the lowest-index in-service bit. A command write with bit 5 clear has no effect.
- R9: A new rising edge on a line in the same cycle as the first-pulse edge that acknowledges that line leaves a fresh pending request on it.
- R10: An end-of-interrupt command in the same cycle as a first-pulse edge takes effect together with it. Arbitration uses the in-service set as it was before that edge.
- R11: While `vec_oe_o` is low, `vec_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Device request lines, recorded on rising edge |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0: mask load, 1: command |
| wr_data_i | input | 8 | Write data (mask, or command with EOI at bit 5) |
| inta_i | input | 1 | Acknowledge pulses from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| vec_oe_o | output | 1 | Drive-enable for the vector bus |
| vec_o | output | 8 | Vector number, zero when not driven |

## Verification
Two pairs of events can land on the same clock edge. The first is a fresh request edge that coincides with the first acknowledge of the same line. The second is an end-of-interrupt write that coincides with a first acknowledge. The bench drives both at the same falling edge. It then judges the outcome through `int_o`, the vector returned by the following handshake, and the interrupt state after a later end-of-interrupt, all compared against a bench model that applies the clear before the set. Random sequences of request edges, mask loads, handshakes and end-of-interrupt writes then run against the same model.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    // Acknowledge handshake phases
    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_WAIT2 = 2'd1,
        ACK_DRIVE = 2'd2
    } ack_phase_e;

    // Command-word bit that requests a non-specific end of interrupt
    localparam int unsigned CMD_EOI_BIT = 5;

endpackage

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] sig_d, sig_q;

    always_comb begin
        sig_d  = sig_i;
        rise_o = sig_i & ~sig_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sig_q <= '0;
        else         sig_q <= sig_d;
    end

endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
    parameter int unsigned N = 8,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          vld_o,
    output logic [N-1:0]  onehot_o,
    output logic [IW-1:0] idx_o
);

    // Lowest index wins: scan downwards so the last hit is the lowest
    always_comb begin
        vld_o    = 1'b0;
        onehot_o = '0;
        idx_o    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                vld_o       = 1'b1;
                onehot_o    = '0;
                onehot_o[i] = 1'b1;
                idx_o       = IW'(i);
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int unsigned N_IRQ    = 8,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_BASE = 32,
    parameter int unsigned CMD_W    = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [CMD_W-1:0] wr_data_i,
    input  logic             inta_i,
    output logic             int_o,
    output logic             vec_oe_o,
    output logic [VEC_W-1:0] vec_o
);

    localparam int unsigned IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    typedef struct packed {
        logic [N_IRQ-1:0] imr;
        logic [N_IRQ-1:0] irr;
        logic [N_IRQ-1:0] isr;
        ack_phase_e       phase;
        logic [IW-1:0]    idx;
    } state_t;

    state_t s_d, s_q;

    logic [N_IRQ-1:0] irq_rise;
    logic [0:0]       inta_rise;
    logic [N_IRQ-1:0] isr_top;
    logic [N_IRQ-1:0] allowed;
    logic [N_IRQ-1:0] eligible;
    logic             cand_vld;
    logic [N_IRQ-1:0] cand_oh;
    logic [IW-1:0]    cand_idx;
    logic [N_IRQ-1:0] ack_set;
    logic             eoi_cmd;
    logic             mask_wr;

    // Plain views of state for the bound checker
    logic [N_IRQ-1:0] imr_q, irr_q, isr_q;
    assign imr_q = s_q.imr;
    assign irr_q = s_q.irr;
    assign isr_q = s_q.isr;

    irq_rise_det #(.W(N_IRQ)) u_irq_rise (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sig_i  (irq_i),
        .rise_o (irq_rise)
    );

    irq_rise_det #(.W(1)) u_inta_rise (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sig_i  (inta_i),
        .rise_o (inta_rise)
    );

    // Highest-priority in-service bit; lines below it may still interrupt
    assign isr_top  = s_q.isr & (~s_q.isr + N_IRQ'(1));
    assign allowed  = isr_top - N_IRQ'(1);
    assign eligible = s_q.irr & ~s_q.imr & allowed;

    irq_first_set #(.N(N_IRQ)) u_resolver (
        .req_i    (eligible),
        .vld_o    (cand_vld),
        .onehot_o (cand_oh),
        .idx_o    (cand_idx)
    );

    assign eoi_cmd = wr_en_i & wr_sel_i & wr_data_i[CMD_EOI_BIT];
    assign mask_wr = wr_en_i & ~wr_sel_i;

    always_comb begin
        s_d     = s_q;
        ack_set = '0;

        if (mask_wr) s_d.imr = wr_data_i[N_IRQ-1:0];

        unique case (s_q.phase)
            ACK_IDLE: begin
                if (inta_rise[0]) begin
                    s_d.phase = ACK_WAIT2;
                    if (cand_vld) begin
                        ack_set = cand_oh;
                        s_d.idx = cand_idx;
                    end else begin
                        s_d.idx = IW'(N_IRQ - 1);
                    end
                end
            end
            ACK_WAIT2: begin
                if (inta_rise[0]) s_d.phase = ACK_DRIVE;
            end
            ACK_DRIVE: begin
                if (!inta_i) s_d.phase = ACK_IDLE;
            end
            default: s_d.phase = ACK_IDLE;
        endcase

        // Clear before set: a fresh edge on an acknowledged line survives
        s_d.irr = (s_q.irr & ~ack_set) | irq_rise;
        s_d.isr = (s_q.isr & ~(eoi_cmd ? isr_top : '0)) | ack_set;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.imr   <= '1;
            s_q.irr   <= '0;
            s_q.isr   <= '0;
            s_q.phase <= ACK_IDLE;
            s_q.idx   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign int_o    = (s_q.phase == ACK_IDLE) && cand_vld;
    assign vec_oe_o = (s_q.phase == ACK_DRIVE);
    assign vec_o    = vec_oe_o ? (VEC_W'(VEC_BASE) + VEC_W'(s_q.idx)) : '0;

endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
    import prio_irq_pkg::*;
#(
    parameter int unsigned N_IRQ    = 8,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_BASE = 32,
    parameter int unsigned CMD_W    = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             inta_i,
    input logic             wr_en_i,
    input logic             wr_sel_i,
    input logic [CMD_W-1:0] wr_data_i,
    input logic             int_o,
    input logic             vec_oe_o,
    input logic [VEC_W-1:0] vec_o,
    input logic [N_IRQ-1:0] imr_q,
    input logic [N_IRQ-1:0] isr_q
);

    p_idle_vec_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vec_oe_o |-> (vec_o == '0));

    p_vec_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_oe_o |-> (vec_o >= VEC_W'(VEC_BASE) && vec_o <= VEC_W'(VEC_BASE + N_IRQ - 1)));

    p_oe_after_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(vec_oe_o) |-> $past(inta_i));

    p_ack_drops_int_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int_o && $rose(inta_i)) |=> !int_o);

    p_ack_moves_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int_o && $rose(inta_i)) |=> (isr_q != $past(isr_q)));

    p_quiet_in_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_oe_o |-> !int_o);

    p_all_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (imr_q == '1) |-> !int_o);

    p_eoi_retires_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i && wr_data_i[CMD_EOI_BIT] && (isr_q != '0) && !$rose(inta_i))
        |=> ($countones(isr_q) + 1 == $past($countones(isr_q))));

endmodule

bind prio_irq_ctrl prio_irq_chk #(
    .N_IRQ    (N_IRQ),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .CMD_W    (CMD_W)
) u_prio_irq_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inta_i    (inta_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .int_o     (int_o),
    .vec_oe_o  (vec_oe_o),
    .vec_o     (vec_o),
    .imr_q     (imr_q),
    .isr_q     (isr_q)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       inta = 1'b0;
    logic       int_o;
    logic       vec_oe;
    logic [7:0] vec;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;

    logic [7:0] m_imr = 8'hFF;
    logic [7:0] m_irr = '0;
    logic [7:0] m_isr = '0;
    logic [7:0] lvl = '0;

    always #10 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .irq_i     (irq),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .inta_i    (inta),
        .int_o     (int_o),
        .vec_oe_o  (vec_oe),
        .vec_o     (vec)
    );

    // Eligible line: unmasked pending with index below every in-service line
    function automatic int exp_idx(input logic [7:0] irr, input logic [7:0] imr,
                                   input logic [7:0] isr);
        int lim = 8;
        for (int i = 7; i >= 0; i--) if (isr[i]) lim = i;
        for (int i = 0; i < lim; i++) if (irr[i] && !imr[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] drop_low(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return v & ~(8'(1) << i);
        return v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_int(input string req);
        chk(req, int'(int_o), (exp_idx(m_irr, m_imr, m_isr) >= 0) ? 1 : 0);
    endtask

    task automatic set_irq(input logic [7:0] v);
        irq = v;
        m_irr |= v & ~lvl;
        lvl = v;
        tick();
    endtask

    task automatic write(input bit sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        if (!sel) m_imr = d;
        else if (d[5]) m_isr = drop_low(m_isr);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic ack(input string req, input logic [7:0] new_rise, input bit with_eoi);
        int e = exp_idx(m_irr, m_imr, m_isr);
        int v = 32 + ((e < 0) ? 7 : e);
        irq = lvl | new_rise;
        if (with_eoi) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h20; end
        inta = 1'b1;
        if (with_eoi) m_isr = drop_low(m_isr);
        if (e >= 0) begin
            m_isr |= 8'(1) << e;
            m_irr &= ~(8'(1) << e);
        end
        m_irr |= new_rise & ~lvl;
        lvl = lvl | new_rise;
        tick();
        wr_en = 1'b0;
        chk({req, " int low in handshake"}, int'(int_o), 0);
        chk({req, " oe low after pulse 1"}, int'(vec_oe), 0);
        tick();
        inta = 1'b0;
        tick();
        tick();
        inta = 1'b1;
        tick();
        chk({req, " R6 oe"}, int'(vec_oe), 1);
        chk({req, " R6 vector"}, int'(vec), v);
        tick();
        chk({req, " R6 vector held"}, int'(vec), v);
        inta = 1'b0;
        tick();
        chk({req, " R6 oe released"}, int'(vec_oe), 0);
        chk({req, " R11 bus zero"}, int'(vec), 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 int", int'(int_o), 0);
        chk("R1 oe", int'(vec_oe), 0);
        chk("R1 vec", int'(vec), 0);
        set_irq(8'h08);
        chk("R1 masked after reset", int'(int_o), 0);
        set_irq(8'h00);
        // R2 and R3: recorded edge survives the line falling, unmask delivers it
        write(1'b0, 8'h00);
        check_int("R3 unmask delivers");
        chk("R2 sticky request", int'(int_o), 1);
        ack("R5", 8'h00, 1'b0);
        write(1'b1, 8'h20);
        check_int("R8");

        // R4 and R5: priority among several, in-service blocks lower lines
        set_irq(8'h24);
        set_irq(8'h00);
        check_int("R2");
        ack("R5", 8'h00, 1'b0);
        check_int("R4 lower blocked");
        set_irq(8'h02);
        set_irq(8'h00);
        check_int("R4 higher preempts");
        ack("R4", 8'h00, 1'b0);
        write(1'b1, 8'h20);
        check_int("R8 eoi one level");
        write(1'b1, 8'h00);
        check_int("R8 non-eoi command ignored");
        chk("R8 non-eoi int stays low", int'(int_o), 0);
        write(1'b1, 8'h20);
        check_int("R8 eoi releases lower");
        ack("R5", 8'h00, 1'b0);
        write(1'b1, 8'h20);

        // R3: masked line skipped in arbitration, kept pending
        write(1'b0, 8'h02);
        set_irq(8'h42);
        set_irq(8'h00);
        ack("R3", 8'h00, 1'b0);
        write(1'b1, 8'h20);
        check_int("R3 masked pending silent");
        write(1'b0, 8'h00);
        check_int("R3 unmask");
        ack("R3", 8'h00, 1'b0);
        write(1'b1, 8'h20);

        // R7: spurious acknowledge
        check_int("R7 idle");
        ack("R7", 8'h00, 1'b0);
        check_int("R7 state unchanged");

        // R9: fresh edge on the line being acknowledged
        set_irq(8'h10);
        set_irq(8'h00);
        ack("R9", 8'h10, 1'b0);
        check_int("R9 same line in service");
        write(1'b1, 8'h20);
        check_int("R9 fresh request remains");
        ack("R9", 8'h00, 1'b0);
        set_irq(8'h00);
        write(1'b1, 8'h20);

        // R10: end of interrupt together with first pulse
        set_irq(8'h09);
        set_irq(8'h00);
        ack("R10", 8'h00, 1'b0);
        ack("R10", 8'h00, 1'b1);
        check_int("R10 both applied");
        ack("R10", 8'h00, 1'b0);
        write(1'b1, 8'h20);

        // Random mix against the model
        for (int n = 0; n < 400; n++) begin
            case ($urandom % 6)
                0, 1: set_irq(8'($urandom));
                2:    write(1'b0, 8'($urandom & $urandom & $urandom));
                3:    ack("R5", 8'h00, 1'b0);
                4:    write(1'b1, 8'h20);
                default: tick();
            endcase
            check_int("R4 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule